// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

A byte-addressed general-purpose I/O peripheral that splits its pins into two banks: a core bank holding the low-numbered pins and a resume bank holding the rest. Software reaches both banks through a small register bus with single-byte reads and writes. Each bank holds seven per-pin controls and one unused slot. The controls are pin enable, direction, output level, rising-edge arm, falling-edge arm, interrupt enable and a sticky edge status.

Pin inputs are first passed through a two-flop synchronizer. The synchronized value is used for level readback and for edge detection. An armed edge on an enabled pin sets that pin's status bit. The bit stays set until software writes a 1 to it. Every status bit whose interrupt enable is set feeds one level-sensitive summary interrupt. Pins that are enabled and programmed as outputs drive their stored level on `pin_out` and raise `pin_oe`.

Top module: `gpio2b`

## Requirements
- R1: After reset, every pin reads back as an input (direction bits all 1). `pin_oe` is all 0, and the status and `irq_out` are 0. Both arm registers and the interrupt-enable register are 0. The enable register reads back the reset value given by its parameter, which defaults to all ones.
- R2: Address bit 5 selects the bank: 0 for core, 1 for resume. Bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising arm, 4 falling arm, 5 interrupt enable, 6 unused, 7 status. Bits 1:0 select the byte. Inside a bank, pin n sits in byte n/8 at bit n%8. Pin index p at or above CORE_PINS is resume-bank pin p-CORE_PINS. The unused register and all bits above a bank's pin count read 0 and ignore writes.
- R3: A direction bit of 0 makes the pin an output. An enabled output pin drives its stored level on `pin_out` and asserts `pin_oe`.
- R4: A write to the level register changes only the bits of pins that are currently outputs. Level bits of input pins keep their old value.
- R5: The level register reads the synchronized pin value for inputs, visible two clock edges after the pin changes. For outputs it reads the stored level. A disabled pin reads 0 and never drives (`pin_oe` and `pin_out` both 0).
- R6: A synchronized 0-to-1 transition on an enabled pin whose rising arm is set makes its status bit 1. The bit is visible three edges after the pin input changes.
- R7: The falling arm works the same way on 1-to-0 transitions. With both arms set, either edge sets status. An edge that is not armed leaves status at 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and set bits stay set until cleared.
- R9: When a new armed edge and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_out` is 1 exactly while some status bit with its interrupt-enable bit set is 1. Status bits with interrupt enable 0 do not raise it, and they stay pending.
- R11: Edges on a disabled pin do not set its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Byte address for register reads and writes |
| reg_wen | input | 1 | Write strobe; writes reg_wdata at reg_addr on the clock edge |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for reg_addr, combinational |
| pin_in | input | CORE_PINS+RESUME_PINS | Asynchronous pin inputs |
| pin_out | output | CORE_PINS+RESUME_PINS | Driven pin levels |
| pin_oe | output | CORE_PINS+RESUME_PINS | Per-pin output enable |
| irq_out | output | 1 | Level-sensitive summary interrupt |

## Verification
Edge detection is tested with a pin armed for rising only, a pin armed for falling only, and a resume-bank pin armed for both edges. Each pin is driven through both transitions, so a swapped or missing polarity leaves a wrong status byte. The level register is written with all ones while pins are inputs, and with a mixed pattern after only some pins have become outputs. This separates masked writes from plain writes. It also shows that a pin switched to output later still holds its old level. The bench also lands a clear in the same cycle as a fresh edge, and toggles a disabled pin. Together these separate edge-wins priority from clear-wins priority, and gated detection from ungated detection.

// File: rtl/gpio2b_pkg.sv
// Package: register selector encoding shared by the GPIO banks and the top.
package gpio2b_pkg;

    // Largest pin count a bank may have (four bytes per register).
    localparam int BANK_MAX_PINS = 32;

    // Register selector, taken from address bits 4:2.
    typedef enum logic [2:0] {
        RG_EN   = 3'd0,
        RG_DIR  = 3'd1,
        RG_LVL  = 3'd2,
        RG_RISE = 3'd3,
        RG_FALL = 3'd4,
        RG_IE   = 3'd5,
        RG_RSVD = 3'd6,
        RG_STS  = 3'd7
    } greg_e;

endpackage

// File: rtl/gpio2b_sync.sv
// Module: gpio2b_sync
// Two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio2b_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two register stages, cleared to 0 by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

endmodule

// File: rtl/gpio2b_bank.sv
// Module: gpio2b_bank
// One GPIO bank. Holds the per-pin register file, edge detection, sticky
// write-1-to-clear status and the bank interrupt.
// Assumes pin_sync is already synchronized to clk and PINS <= 32.
// The read port is combinational from acc_reg/acc_byte.
module gpio2b_bank
    import gpio2b_pkg::*;
#(
    parameter int          PINS   = 8,
    parameter logic [31:0] EN_RST = 32'hFFFF_FFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_sync,
    input  logic            wr_en,
    input  greg_e           acc_reg,
    input  logic [1:0]      acc_byte,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            irq
);

    localparam int REG_W = BANK_MAX_PINS;

    logic [PINS-1:0] en_q, dir_q, lvl_q, rise_q, fall_q, ie_q, sts_q, prev_q;
    logic [PINS-1:0] lane, wbits, clr_v, set_v, lvl_view, rise_ev, fall_ev;
    logic            hit_en, hit_dir, hit_lvl, hit_rise, hit_fall, hit_ie, hit_sts;
    logic [REG_W-1:0] rd_vec;

    // Map the selected byte lane onto pin bits, with the write byte replicated.
    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            lane[i]  = ((i / 8) == int'(acc_byte));
            wbits[i] = wr_data[3'(i % 8)];
        end
    end

    // Decode the write strobe into one hit per register.
    always_comb begin
        hit_en   = wr_en && (acc_reg == RG_EN);
        hit_dir  = wr_en && (acc_reg == RG_DIR);
        hit_lvl  = wr_en && (acc_reg == RG_LVL);
        hit_rise = wr_en && (acc_reg == RG_RISE);
        hit_fall = wr_en && (acc_reg == RG_FALL);
        hit_ie   = wr_en && (acc_reg == RG_IE);
        hit_sts  = wr_en && (acc_reg == RG_STS);
    end

    // Edge events on enabled pins, and armed events that set status.
    always_comb begin
        rise_ev = pin_sync & ~prev_q & en_q;
        fall_ev = ~pin_sync & prev_q & en_q;
        set_v   = (rise_ev & rise_q) | (fall_ev & fall_q);
        clr_v   = hit_sts ? (lane & wbits) : '0;
    end

    // Control registers: plain byte-lane writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= EN_RST[PINS-1:0];
            dir_q  <= '1;
            rise_q <= '0;
            fall_q <= '0;
            ie_q   <= '0;
        end else begin
            if (hit_en)   en_q   <= (en_q   & ~lane) | (wbits & lane);
            if (hit_dir)  dir_q  <= (dir_q  & ~lane) | (wbits & lane);
            if (hit_rise) rise_q <= (rise_q & ~lane) | (wbits & lane);
            if (hit_fall) fall_q <= (fall_q & ~lane) | (wbits & lane);
            if (hit_ie)   ie_q   <= (ie_q   & ~lane) | (wbits & lane);
        end
    end

    // Output level register: only pins that are outputs accept writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (hit_lvl) begin
            lvl_q <= (lvl_q & ~(lane & ~dir_q)) | (wbits & lane & ~dir_q);
        end
    end

    // Previous synchronized sample, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    // Sticky status: a fresh edge overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_v) | set_v;
    end

    // Level readback: input value, stored level, or 0 when disabled.
    assign lvl_view = en_q & ((dir_q & pin_sync) | (~dir_q & lvl_q));

    // Pin drive: only enabled outputs drive.
    assign pin_oe  = en_q & ~dir_q;
    assign pin_out = lvl_q & en_q & ~dir_q;

    // Bank interrupt from enabled pending status.
    assign irq = |(sts_q & ie_q);

    // Read multiplexer: zero-extended register, then byte select.
    always_comb begin
        case (acc_reg)
            RG_EN:   rd_vec = REG_W'(en_q);
            RG_DIR:  rd_vec = REG_W'(dir_q);
            RG_LVL:  rd_vec = REG_W'(lvl_view);
            RG_RISE: rd_vec = REG_W'(rise_q);
            RG_FALL: rd_vec = REG_W'(fall_q);
            RG_IE:   rd_vec = REG_W'(ie_q);
            RG_STS:  rd_vec = REG_W'(sts_q);
            default: rd_vec = '0;
        endcase
        case (acc_byte)
            2'd0:    rd_data = rd_vec[7:0];
            2'd1:    rd_data = rd_vec[15:8];
            2'd2:    rd_data = rd_vec[23:16];
            default: rd_data = rd_vec[31:24];
        endcase
    end

    AST_LVL_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lvl |=> (((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0)); // R4

    AST_STS_ONLY_CLEARED_BY_W1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~sts_q & $past(sts_q) & ~$past(clr_v)) == '0)); // R8

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((sts_q & $past(set_v)) == $past(set_v))); // R9

    AST_DISABLED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~en_q) == '0) && ((pin_out & ~pin_oe) == '0)); // R5

    AST_DISABLED_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0)); // R11

endmodule

// File: rtl/gpio2b.sv
// Module: gpio2b
// Two-bank GPIO controller top. Synchronizes pins, decodes the byte
// address into bank/register/byte, and merges the read data and interrupts.
// Assumes 1 <= CORE_PINS <= 32 and 1 <= RESUME_PINS <= 32.
// Pins [CORE_PINS-1:0] belong to the core bank; the rest belong to the resume bank.
module gpio2b
    import gpio2b_pkg::*;
#(
    parameter int          CORE_PINS     = 10,
    parameter int          RESUME_PINS   = 4,
    parameter logic [31:0] CORE_EN_RST   = 32'hFFFF_FFFF,
    parameter logic [31:0] RESUME_EN_RST = 32'hFFFF_FFFF,
    localparam int         NPINS         = CORE_PINS + RESUME_PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       reg_addr,
    input  logic             reg_wen,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_out
);

    logic [NPINS-1:0] pin_sync;
    logic             bank_sel;
    greg_e            acc_reg;
    logic [1:0]       acc_byte;
    logic [7:0]       bank_rd [2];
    logic [1:0]       bank_irq;

    // Address fields: bank select, register select, byte lane.
    assign bank_sel = reg_addr[5];
    assign acc_reg  = greg_e'(reg_addr[4:2]);
    assign acc_byte = reg_addr[1:0];

    gpio2b_sync #(.WIDTH(NPINS)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int          BP   = (b == 0) ? CORE_PINS : RESUME_PINS;
        localparam int          BASE = (b == 0) ? 0 : CORE_PINS;
        localparam logic [31:0] ERST = (b == 0) ? CORE_EN_RST : RESUME_EN_RST;

        logic [BP-1:0] b_out;
        logic [BP-1:0] b_oe;

        gpio2b_bank #(.PINS(BP), .EN_RST(ERST)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_sync(pin_sync[BASE +: BP]),
            .wr_en   (reg_wen && (bank_sel == 1'(b))),
            .acc_reg (acc_reg),
            .acc_byte(acc_byte),
            .wr_data (reg_wdata),
            .rd_data (bank_rd[b]),
            .pin_out (b_out),
            .pin_oe  (b_oe),
            .irq     (bank_irq[b])
        );

        assign pin_out[BASE +: BP] = b_out;
        assign pin_oe[BASE +: BP]  = b_oe;
    end

    // Read data from the selected bank.
    assign reg_rdata = bank_sel ? bank_rd[1] : bank_rd[0];

    // Summary interrupt: any bank pending.
    assign irq_out = |bank_irq;

    AST_IRQ_DROPS_ON_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq_out); // R1

endmodule

// File: tb/gpio2b_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, a monitor compares them.
module gpio2b_tb_top;

    localparam int NP = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic          reg_wen = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int          kind;   // 0 rdata, 1 pin_out, 2 pin_oe, 3 irq
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    gpio2b dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic exp_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.kind = 0; it.exp = {8'h00, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_sig(input int k, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = k; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pin_in[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = {8'h00, reg_rdata};
                    1:       act = {2'b00, pin_out};
                    2:       act = {2'b00, pin_oe};
                    default: act = {15'd0, irq_out};
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_rd(6'h04, 8'hFF, "R1 core dir byte0");
        exp_rd(6'h05, 8'h03, "R1 core dir byte1");
        exp_rd(6'h24, 8'h0F, "R1 resume dir");
        exp_rd(6'h00, 8'hFF, "R1 core enable");
        exp_rd(6'h0C, 8'h00, "R1 rising arm");
        exp_rd(6'h14, 8'h00, "R1 irq enable");
        exp_rd(6'h1C, 8'h00, "R1 status");
        exp_sig(2, 16'h0000, "R1 pin_oe");
        exp_sig(3, 16'h0000, "R1 irq_out");

        // R4 level write ignored on inputs; R5 input readback
        wr(6'h08, 8'hFF);
        exp_rd(6'h08, 8'h00, "R4 level write on inputs");
        exp_sig(1, 16'h0000, "R4 pin_out");
        set_pin(3, 1'b1);
        exp_rd(6'h08, 8'h08, "R5 input readback");

        // R3 outputs, R4 masked write
        wr(6'h04, 8'hF0);
        exp_sig(2, 16'h000F, "R3 pin_oe");
        wr(6'h08, 8'hA5);
        exp_rd(6'h08, 8'h05, "R4 mixed level write");
        exp_sig(1, 16'h0005, "R3 pin_out");
        wr(6'h04, 8'hE0);
        exp_rd(6'h08, 8'h05, "R4 pin4 kept old level");
        exp_sig(2, 16'h001F, "R3 pin_oe pin4");

        // R5 disabled pin
        wr(6'h00, 8'hFE);
        exp_sig(2, 16'h001E, "R5 disabled oe");
        exp_sig(1, 16'h0004, "R5 disabled out");
        exp_rd(6'h08, 8'h04, "R5 disabled readback");
        wr(6'h00, 8'hFF);
        wr(6'h04, 8'hFF);
        set_pin(3, 1'b0);

        // R2 map, resume bank, unused space
        set_pin(12, 1'b1);
        exp_rd(6'h28, 8'h04, "R2 resume pin2 level");
        exp_rd(6'h09, 8'h00, "R2 core byte1 level");
        set_pin(9, 1'b1);
        exp_rd(6'h09, 8'h02, "R2 core pin9 level");
        wr(6'h18, 8'hFF);
        exp_rd(6'h18, 8'h00, "R2 unused register");
        wr(6'h07, 8'hFF);
        exp_rd(6'h07, 8'h00, "R2 byte beyond pins");

        // R6 rising edge, R10 gating, R8 clear
        wr(6'h0C, 8'h01);
        set_pin(0, 1'b1);
        exp_rd(6'h1C, 8'h01, "R6 rising status");
        exp_sig(3, 16'h0000, "R10 masked irq");
        wr(6'h14, 8'h01);
        exp_sig(3, 16'h0001, "R10 irq raised");
        set_pin(0, 1'b0);
        exp_rd(6'h1C, 8'h01, "R8 sticky");
        wr(6'h1C, 8'h00);
        exp_rd(6'h1C, 8'h01, "R8 write 0 no effect");
        wr(6'h1C, 8'h01);
        exp_rd(6'h1C, 8'h00, "R8 write 1 clears");
        exp_sig(3, 16'h0000, "R10 irq dropped");

        // R7 falling only and both edges
        wr(6'h10, 8'h02);
        set_pin(1, 1'b1);
        exp_rd(6'h1C, 8'h00, "R7 rise ignored falling-only");
        set_pin(1, 1'b0);
        exp_rd(6'h1C, 8'h02, "R7 falling status");
        wr(6'h1C, 8'h02);
        wr(6'h2C, 8'h04);
        wr(6'h30, 8'h04);
        set_pin(12, 1'b0);
        exp_rd(6'h3C, 8'h04, "R7 both-edge fall");
        wr(6'h3C, 8'h04);
        exp_rd(6'h3C, 8'h00, "R8 resume clear");
        set_pin(12, 1'b1);
        exp_rd(6'h3C, 8'h04, "R7 both-edge rise");
        wr(6'h34, 8'h04);
        exp_sig(3, 16'h0001, "R10 resume irq");
        wr(6'h34, 8'h00);
        exp_sig(3, 16'h0000, "R10 resume masked");
        exp_rd(6'h3C, 8'h04, "R10 pending kept");
        wr(6'h3C, 8'h04);

        // R9 edge wins over same-cycle clear
        wr(6'h14, 8'h00);
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        wr(6'h1C, 8'h01);
        exp_rd(6'h1C, 8'h01, "R9 edge beats clear");
        wr(6'h1C, 8'h01);
        exp_rd(6'h1C, 8'h00, "R9 plain clear");
        set_pin(0, 1'b0);

        // R11 disabled pin ignores edges
        wr(6'h10, 8'h01);
        wr(6'h00, 8'hFE);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        exp_rd(6'h1C, 8'h00, "R11 disabled no status");
        wr(6'h00, 8'hFF);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule